// File: doc/BRIEF.md
# Card Clock Divider Programmer

This block turns a rate request into a setting for a card clock divider, then reports the card rate the setting actually gives. A request carries two integers: the rate of the source clock and the card rate wanted. The card-host controller downstream halves whatever clock it receives. To cancel that, the block aims the divider at twice the wanted rate, and it rounds the divider value upward so the card never runs faster than asked. The block then computes the achieved card rate, which is the divided source rate halved again, and returns it together with the divider value.

The block also holds the clock generator that the divider value drives. The generator divides the block clock by N+1. It takes a new value only when its current period ends, so a change never produces a short or stretched pulse. It puts out a clock level and a one-cycle period-start tick.

Requests come in and results go out on valid/ready channels. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is being worked on. Once `rsp_valid` is raised, the result stays on the port, unchanged, until the cycle where `rsp_ready` is high.

Top module: `cardclk_divprog`

## Requirements
- R1: For a non-zero request, `rsp_div` equals ceil(H / F), where H = floor(src / 2) and F is the requested rate. The division is done with a restoring divider that produces one quotient bit per cycle.
- R2: If the ceiling value is above 63, the largest value the 6-bit divider field can hold, the result has `rsp_err` = 1, `rsp_div` = 0 and `rsp_rate` = 0, and the generated clock keeps its previous divider.
- R3: A requested rate of 0 gives `rsp_err` = 1, `rsp_div` = 0 and `rsp_rate` = 0 without starting a division, and the generated clock keeps its previous divider.
- R4: For an accepted divider N, `rsp_rate` equals floor(floor(src / (N+1)) / 2) with `rsp_err` = 0, and this value never exceeds the requested rate.
- R5: Once a divider N is applied, `card_tick_o` is high for exactly one cycle every N+1 clock cycles, in the first cycle of each period.
- R6: A new divider takes effect only at the end of the running period. The period that is in progress when the new value is accepted completes with its old length.
- R7: In each period of length P = N+1, `card_clk_o` is high for the first floor(P/2) cycles and low for the rest. When N = 0, `card_clk_o` stays low and `card_tick_o` stays high.
- R8: `req_ready` is low from the cycle after a request is taken until its result has been handed over. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_div`, `rsp_rate` and `rsp_err` hold their values.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0, and the generator runs with divider RESET_DIV (default 3, giving a 4-cycle period that is high for 2 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source the generator divides |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_src_rate | input | RATE_W | Source clock rate, integer |
| req_freq | input | RATE_W | Wanted card rate, integer |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_div | output | DIV_W | Divider value chosen (0 on error) |
| rsp_rate | output | RATE_W | Achieved card rate (0 on error) |
| rsp_err | output | 1 | Request rejected (zero rate or divider out of range) |
| card_clk_o | output | 1 | Divided clock level |
| card_tick_o | output | 1 | First cycle of each divided period |

## Verification
The embedded properties assume that the request fields are stable while `req_valid` waits for `req_ready`. They also assume that `rsp_ready` may change in any cycle with no relation to `rsp_valid`. The bench drives inputs only between clock edges and holds each request until it has been accepted. It toggles `rsp_ready` on a fixed pattern that makes some results wait. The stimulus deliberately includes zero rates, ceiling values just below and just above 63, and full-width source rates, because the block has to handle these rather than assume them away. The divider change is issued in the middle of a long period so that the switch-at-period-end rule is exercised.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_LAUNCH_A,
    CS_WAIT_A,
    CS_LAUNCH_B,
    CS_WAIT_B,
    CS_REPLY
  } ctl_state_e;

endpackage

// File: rtl/cdp_seqdiv.sv
module cdp_seqdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     q_r, r_r, d_r;
  logic [CNT_W-1:0] cnt_r;
  logic             busy_r, done_r;

  logic [W:0]   trial, diff;
  logic [W-1:0] q_nx, r_nx;

  // one restoring step: shift in next dividend bit, try subtract
  always_comb begin
    trial = {r_r, q_r[W-1]};
    diff  = trial - {1'b0, d_r};
    if (!diff[W]) begin
      r_nx = diff[W-1:0];
      q_nx = {q_r[W-2:0], 1'b1};
    end else begin
      r_nx = trial[W-1:0];
      q_nx = {q_r[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !busy_r) begin
        q_r    <= dividend;
        r_r    <= '0;
        d_r    <= divisor;
        cnt_r  <= CNT_W'(W);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        q_r   <= q_nx;
        r_r   <= r_nx;
        cnt_r <= cnt_r - CNT_W'(1);
        if (cnt_r == CNT_W'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> divisor != '0);                                  // R3
  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_r);                                        // R8
  AST_DIV_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> r_r < d_r);                                     // R1
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);                                       // R1

endmodule

// File: rtl/cdp_clkgen.sv
module cdp_clkgen #(
  parameter int DIV_W     = 6,
  parameter int RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             clk_o,
  output logic             tick_o
);
  localparam int   RST_HI  = (RESET_DIV + 1) / 2;
  localparam logic RST_CLK = (RST_HI > 0);

  logic [DIV_W-1:0] cur_n, pend_n, cnt;
  logic             pend_v, clk_q, tick_q;

  logic             wrap;
  logic [DIV_W-1:0] n_nx, cnt_nx;
  logic [DIV_W:0]   per_nx, hi_len;

  always_comb begin
    wrap   = (cnt == cur_n);
    n_nx   = (wrap && pend_v) ? pend_n : cur_n;
    cnt_nx = wrap ? '0 : cnt + DIV_W'(1);
    per_nx = {1'b0, n_nx} + (DIV_W+1)'(1);
    hi_len = per_nx >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_n  <= DIV_W'(RESET_DIV);
      pend_n <= '0;
      pend_v <= 1'b0;
      cnt    <= '0;
      clk_q  <= RST_CLK;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt_nx;
      cur_n  <= n_nx;
      clk_q  <= ({1'b0, cnt_nx} < hi_len);
      tick_q <= (cnt_nx == '0);
      if (load) begin
        pend_n <= load_val;
        pend_v <= 1'b1;
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != cur_n) |=> $stable(cur_n));                        // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_n);                                             // R5
  AST_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cur_n) |-> !clk_o);                                // R7
  AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cur_n != '0) |-> clk_o);                        // R7

endmodule

// File: rtl/cdp_ctrl.sv
module cdp_ctrl
  import cdp_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_src,
  input  logic [RATE_W-1:0] req_freq,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DIV_W-1:0]  rsp_div,
  output logic [RATE_W-1:0] rsp_rate,
  output logic              rsp_err,
  output logic              div_start,
  output logic [RATE_W-1:0] div_dividend,
  output logic [RATE_W-1:0] div_divisor,
  input  logic              div_done,
  input  logic [RATE_W-1:0] div_quot,
  input  logic [RATE_W-1:0] div_rem,
  output logic              gen_load,
  output logic [DIV_W-1:0]  gen_val
);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam int PW      = 2 * RATE_W;

  ctl_state_e        state;
  logic [RATE_W-1:0] src_r, freq_r, rate_r;
  logic [DIV_W-1:0]  div_r;
  logic              err_r;

  logic [RATE_W-1:0] half_src, ceil_q;
  logic              too_big;

  always_comb begin
    half_src     = src_r >> 1;
    ceil_q       = div_quot + RATE_W'(|div_rem);
    too_big      = ceil_q > RATE_W'(DIV_MAX);
    req_ready    = (state == CS_IDLE);
    rsp_valid    = (state == CS_REPLY);
    div_start    = (state == CS_LAUNCH_A) || (state == CS_LAUNCH_B);
    div_dividend = (state == CS_LAUNCH_A) ? half_src : src_r;
    div_divisor  = (state == CS_LAUNCH_A) ? freq_r
                                          : RATE_W'(div_r) + RATE_W'(1);
    gen_load     = (state == CS_WAIT_A) && div_done && !too_big;
    gen_val      = ceil_q[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CS_IDLE;
      src_r  <= '0;
      freq_r <= '0;
      rate_r <= '0;
      div_r  <= '0;
      err_r  <= 1'b0;
    end else begin
      unique case (state)
        CS_IDLE: if (req_valid) begin
          src_r  <= req_src;
          freq_r <= req_freq;
          if (req_freq == '0) begin
            err_r  <= 1'b1;
            div_r  <= '0;
            rate_r <= '0;
            state  <= CS_REPLY;
          end else begin
            err_r <= 1'b0;
            state <= CS_LAUNCH_A;
          end
        end
        CS_LAUNCH_A: state <= CS_WAIT_A;
        CS_WAIT_A: if (div_done) begin
          if (too_big) begin
            err_r  <= 1'b1;
            div_r  <= '0;
            rate_r <= '0;
            state  <= CS_REPLY;
          end else begin
            div_r <= ceil_q[DIV_W-1:0];
            state <= CS_LAUNCH_B;
          end
        end
        CS_LAUNCH_B: state <= CS_WAIT_B;
        CS_WAIT_B: if (div_done) begin
          rate_r <= div_quot >> 1;
          state  <= CS_REPLY;
        end
        CS_REPLY: if (rsp_ready) state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign rsp_div  = div_r;
  assign rsp_rate = rate_r;
  assign rsp_err  = err_r;

  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_IDLE && req_valid && req_freq == '0) |=> (rsp_valid && rsp_err)); // R3
  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_WAIT_A && div_done) |->
      (PW'(div_quot) * PW'(freq_r) + PW'(div_rem) == PW'(half_src)));              // R1
  AST_CEIL_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_WAIT_A && div_done) |->
      (PW'(ceil_q) * PW'(freq_r) >= PW'(half_src)) &&
      (ceil_q == '0 || PW'(ceil_q - RATE_W'(1)) * PW'(freq_r) < PW'(half_src)));   // R1
  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_div == '0 && rsp_rate == '0));                 // R2
  AST_RATE_LE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> rsp_rate <= freq_r);                               // R4
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_div) && $stable(rsp_rate) && $stable(rsp_err)));   // R8

endmodule

// File: rtl/cardclk_divprog.sv
module cardclk_divprog #(
  parameter int RATE_W    = 32,
  parameter int DIV_W     = 6,
  parameter int RESET_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_src_rate,
  input  logic [RATE_W-1:0] req_freq,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DIV_W-1:0]  rsp_div,
  output logic [RATE_W-1:0] rsp_rate,
  output logic              rsp_err,
  output logic              card_clk_o,
  output logic              card_tick_o
);
  logic              d_start, d_done;
  logic [RATE_W-1:0] d_dividend, d_divisor, d_quot, d_rem;
  logic              g_load;
  logic [DIV_W-1:0]  g_val;

  cdp_ctrl #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_src      (req_src_rate),
    .req_freq     (req_freq),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_div      (rsp_div),
    .rsp_rate     (rsp_rate),
    .rsp_err      (rsp_err),
    .div_start    (d_start),
    .div_dividend (d_dividend),
    .div_divisor  (d_divisor),
    .div_done     (d_done),
    .div_quot     (d_quot),
    .div_rem      (d_rem),
    .gen_load     (g_load),
    .gen_val      (g_val)
  );

  cdp_seqdiv #(.W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (d_start),
    .dividend (d_dividend),
    .divisor  (d_divisor),
    .done     (d_done),
    .quot     (d_quot),
    .rem      (d_rem)
  );

  cdp_clkgen #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (g_load),
    .load_val (g_val),
    .clk_o    (card_clk_o),
    .tick_o   (card_tick_o)
  );

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                  // R8

endmodule

// File: tb/sim_cardclk_divprog.sv
module sim_cardclk_divprog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_src_rate = '0;
  logic [31:0] req_freq = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [5:0]  rsp_div;
  logic [31:0] rsp_rate;
  logic        rsp_err;
  logic        card_clk_o, card_tick_o;

  always #4 clk = ~clk;

  cardclk_divprog u0 (.*);

  typedef struct {
    logic [5:0]  div;
    logic [31:0] rate;
    logic        err;
    logic        zero_case;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int cur_n = 3;
  bit bp_mode = 1'b0;
  int rdy_cnt = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    rsp_ready <= bp_mode ? (rdy_cnt % 3 == 2) : 1'b1;
  end

  // monitor / scoreboard
  bit          held = 1'b0;
  logic [5:0]  h_div;
  logic [31:0] h_rate;
  logic        h_err;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(rsp_valid, "R8 valid held", longint'(rsp_valid), 1);
        check(rsp_div == h_div && rsp_rate == h_rate && rsp_err == h_err,
              "R8 data held", longint'(rsp_rate), longint'(h_rate));
      end
      held = 1'b0;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_err == e.err, e.zero_case ? "R3 error flag" : "R2 error flag",
                longint'(rsp_err), longint'(e.err));
          check(rsp_div == e.div, "R1 divider", longint'(rsp_div), longint'(e.div));
          check(rsp_rate == e.rate, "R4 achieved rate", longint'(rsp_rate), longint'(e.rate));
        end
      end else if (rsp_valid) begin
        held = 1'b1;
        h_div = rsp_div; h_rate = rsp_rate; h_err = rsp_err;
      end
    end
  end

  task automatic push_exp(input logic [31:0] s, input logic [31:0] f);
    exp_t e;
    longint h, q;
    h = longint'(s) / 2;
    e.zero_case = (f == 0);
    e.err = 1'b0; e.div = '0; e.rate = '0;
    if (f == 0) e.err = 1'b1;
    else begin
      q = (h + longint'(f) - 1) / longint'(f);
      if (q > 63) e.err = 1'b1;
      else begin
        e.div  = 6'(q);
        e.rate = 32'((longint'(s) / (q + 1)) / 2);
        cur_n  = int'(q);
      end
    end
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [31:0] s, input logic [31:0] f);
    @(negedge clk);
    req_src_rate = s; req_freq = f; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready low while busy", longint'(req_ready), 0);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!card_tick_o);
  endtask

  task automatic period_from_here(output int cnt, output int hi);
    cnt = 0; hi = 0;
    do begin
      if (card_clk_o) hi++;
      cnt++;
      @(negedge clk);
    end while (!card_tick_o);
  endtask

  task automatic measure(input string tag);
    int c, h;
    wait_tick();
    period_from_here(c, h);
    check(c == cur_n + 1, {tag, " R5 period"}, c, cur_n + 1);
    check(h == (cur_n + 1) / 2, {tag, " R7 high phase"}, h, (cur_n + 1) / 2);
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] f);
    push_exp(s, f);
    send(s, f);
    while (exp_q.size() != 0) @(negedge clk);
    measure("clock after request");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R9 ready after reset", longint'(req_ready), 1);
    check(!rsp_valid, "R9 no result after reset", longint'(rsp_valid), 0);
    measure("R9 reset divider");

    run(32'd48, 32'd4);                 // N=6, odd period
    bp_mode = 1'b1;
    run(32'd48, 32'd6);                 // N=4 under back-pressure
    run(32'd100_000_000, 32'd25_000_000);
    bp_mode = 1'b0;
    run(32'd20, 32'd10);                // N=1
    run(32'd126, 32'd1);                // N=63 upper edge
    run(32'd128, 32'd1);                // R2 out of range, clock unchanged
    run(32'd1000, 32'd0);               // R3 zero rate, clock unchanged
    run(32'd1, 32'd5);                  // N=0
    run(32'hFFFF_FFFF, 32'h0200_0000);  // R2 just over
    run(32'hFFFF_FFFF, 32'h0210_0000);  // N=63 full width
    bp_mode = 1'b1;
    run(32'd64, 32'd8);
    bp_mode = 1'b0;

    // R6: change requested mid-period of a 64-cycle period
    run(32'd126, 32'd1);
    begin
      int c1, h1, c2, h2;
      wait_tick();
      fork
        begin push_exp(32'd20, 32'd7); send(32'd20, 32'd7); end
        period_from_here(c1, h1);
      join
      check(c1 == 64, "R6 old period completes", c1, 64);
      period_from_here(c2, h2);
      check(c2 == 3, "R6 new period after boundary", c2, 3);
      check(h2 == 1, "R7 odd period high phase", h2, 1);
    end
    while (exp_q.size() != 0) @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule